// File: doc/BRIEF.md
# SDRAM Bank Command Timing Checker

This block is a passive monitor placed beside the command bus of an SDRAM controller. Every clock it samples a command code, a bank address and a row address. For each bank it keeps an open/idle state, the row that was opened, and a count of cycles since the last accepted activate. A single global counter tracks the cycles since the last accepted activate to any bank. Commands that break the row-open rules or the activate spacing rules raise a one-cycle violation pulse with a code that names the broken rule.

The timing limits are given as picosecond parameters together with the clock period. Each limit is converted to a cycle count at elaboration by ceiling division. With the defaults (7.5 ns clock; 20 ns activate-to-access, 65 ns same-bank activate spacing, 15 ns cross-bank activate spacing), the limits are 3, 9 and 2 cycles.

Each bank runs a two-state machine. In BANK_IDLE, an accepted ACTIVE takes the transition "open", which moves the bank to BANK_OPEN and latches the row. In BANK_OPEN, a PRECHARGE takes the transition "close" back to BANK_IDLE. A PRECHARGE in BANK_IDLE takes the self-transition "idle-precharge". All other commands keep the state. A command that is flagged is rejected: it changes no bank state and restarts no counter.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Each cycle limit equals the ceiling of its picosecond limit divided by the clock period. With the defaults, a same-bank ACTIVE 8 cycles after the last accepted one is flagged and one 9 cycles after is accepted.
- R2: A READ (code 2) or WRITE (code 3) to a bank in BANK_IDLE is flagged with violation code 1.
- R3: A READ or WRITE to an open bank fewer than 3 cycles (default) after that bank's accepted ACTIVE is flagged with code 2. At exactly 3 cycles it is accepted.
- R4: An ACTIVE (code 1) to a bank in BANK_OPEN is flagged with code 3, and the bank keeps its row open.
- R5: An ACTIVE to an idle bank fewer than 9 cycles (default) after that bank's last accepted ACTIVE is flagged with code 4.
- R6: An ACTIVE fewer than 2 cycles (default) after the last accepted ACTIVE to any bank is flagged with code 5. At exactly 2 cycles it is accepted.
- R7: A PRECHARGE (code 4) closes the addressed bank. A PRECHARGE to an idle bank gives no violation, and the bank stays idle.
- R8: The outputs are registered and reflect the command sampled at the previous rising edge. At most one code is reported, the lowest applicable one. The violation pulse is high exactly when the code is nonzero, and code 0 means no violation.
- R9: NOP (code 0) and the unused command codes 5 to 7 never raise a violation and change no state.
- R10: After reset all banks are idle, both outputs are 0, and all counters are saturated, so the first ACTIVE to any bank is accepted.
- R11: A flagged ACTIVE neither opens the bank nor restarts its spacing counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5-7 unused |
| bank_i | input | 2 | Bank address |
| row_i | input | ROW_W (13) | Row address, used by ACTIVE |
| viol_o | output | 1 | Violation pulse for the command of the previous cycle |
| viol_code_o | output | 3 | Rule code: 0 none, 1 closed bank, 2 activate-to-access, 3 open bank, 4 same-bank spacing, 5 cross-bank spacing |

## Verification
The same-bank spacing violation is the hardest case to reach. It needs an accepted ACTIVE, a PRECHARGE and a new ACTIVE to the same bank, all inside the nine-cycle window, and the cross-bank spacing rule must not mask it. Random traffic rarely lines up that sequence. A directed sequence therefore opens, closes and reopens one bank, walks the window edge cycle by cycle, and checks that the rejected attempts do not restart the window. Weighted random traffic then mixes all commands over four banks against a cycle-level reference model in the bench.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE   = 3'd0,
        V_CLOSED = 3'd1,
        V_TRCD   = 3'd2,
        V_OPEN   = 3'd3,
        V_TRC    = 3'd4,
        V_TRRD   = 3'd5
    } viol_e;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_OPEN = 1'b1
    } bank_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
    parameter int MAX = 9,
    parameter int W   = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] SAT = W'(MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_o <= SAT;
        end else if (restart_i) begin
            count_o <= W'(1);
        end else if (count_o < SAT) begin
            count_o <= count_o + W'(1);
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_MAX = 9,
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic [CNT_W-1:0] since_act_o
);

    bank_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= BANK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_IDLE: if (act_i) state_d = BANK_OPEN;
            BANK_OPEN: if (pre_i) state_d = BANK_IDLE;
            default:   state_d = BANK_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            row_o <= '0;
        end else if (act_i) begin
            row_o <= row_i;
        end
    end

    assign open_o = (state_q == BANK_OPEN);

    sdram_gap_counter #(
        .MAX(CNT_MAX),
        .W  (CNT_W)
    ) u_since_act (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(act_i),
        .count_o  (since_act_o)
    );

endmodule

// File: rtl/sdram_rule_eval.sv
module sdram_rule_eval
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W = 2,
    parameter int CNT_W = 4,
    parameter int T_RCD = 3,
    parameter int T_RC = 9,
    parameter int T_RRD = 2
) (
    input  cmd_e                             cmd_i,
    input  logic [BANK_W-1:0]                bank_i,
    input  logic [NUM_BANKS-1:0]             open_i,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]  since_bank_i,
    input  logic [CNT_W-1:0]                 since_any_i,
    output viol_e                            code_o
);

    localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);

    logic             sel_open;
    logic [CNT_W-1:0] sel_since;

    assign sel_open  = open_i[bank_i];
    assign sel_since = since_bank_i[bank_i];

    always_comb begin
        code_o = V_NONE;
        unique case (cmd_i)
            CMD_READ, CMD_WRITE: begin
                if (!sel_open)                code_o = V_CLOSED;
                else if (sel_since < LIM_RCD) code_o = V_TRCD;
            end
            CMD_ACT: begin
                if (sel_open)                   code_o = V_OPEN;
                else if (sel_since < LIM_RC)    code_o = V_TRC;
                else if (since_any_i < LIM_RRD) code_o = V_TRRD;
            end
            default: code_o = V_NONE;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int CLK_PS    = 7500,
    parameter int TRCD_PS   = 20000,
    parameter int TRC_PS    = 65000,
    parameter int TRRD_PS   = 15000
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
    input  logic [ROW_W-1:0]             row_i,
    output logic                         viol_o,
    output logic [2:0]                   viol_code_o
);

    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int T_RCD   = ceil_div(TRCD_PS, CLK_PS);
    localparam int T_RC    = ceil_div(TRC_PS, CLK_PS);
    localparam int T_RRD   = ceil_div(TRRD_PS, CLK_PS);
    localparam int MAX_A   = (T_RCD > T_RC) ? T_RCD : T_RC;
    localparam int CNT_MAX = (MAX_A > T_RRD) ? MAX_A : T_RRD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    cmd_e                            cmd;
    viol_e                           code;
    logic                            act_ok;
    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
    logic [NUM_BANKS-1:0][CNT_W-1:0] since_bank;
    logic [CNT_W-1:0]                since_any;

    assign cmd    = cmd_e'(cmd_i);
    assign act_ok = (cmd == CMD_ACT) && (code == V_NONE);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank_i == BANK_W'(b));
        sdram_bank_fsm #(
            .ROW_W  (ROW_W),
            .CNT_MAX(CNT_MAX),
            .CNT_W  (CNT_W)
        ) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .act_i      (act_ok && hit),
            .pre_i      ((cmd == CMD_PRE) && hit),
            .row_i      (row_i),
            .open_o     (bank_open[b]),
            .row_o      (open_row[b]),
            .since_act_o(since_bank[b])
        );
    end

    sdram_gap_counter #(
        .MAX(CNT_MAX),
        .W  (CNT_W)
    ) u_since_any (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(act_ok),
        .count_o  (since_any)
    );

    sdram_rule_eval #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .CNT_W    (CNT_W),
        .T_RCD    (T_RCD),
        .T_RC     (T_RC),
        .T_RRD    (T_RRD)
    ) u_rules (
        .cmd_i       (cmd),
        .bank_i      (bank_i),
        .open_i      (bank_open),
        .since_bank_i(since_bank),
        .since_any_i (since_any),
        .code_o      (code)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            viol_o      <= 1'b0;
            viol_code_o <= 3'd0;
        end else begin
            viol_o      <= (code != V_NONE);
            viol_code_o <= code;
        end
    end

endmodule

// File: rtl/sdram_cmd_rules_sva.sv
module sdram_cmd_rules_sva #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic [2:0]                      cmd_i,
    input logic [$clog2(NUM_BANKS)-1:0]    bank_i,
    input logic                            viol_o,
    input logic [2:0]                      viol_code_o,
    input logic [NUM_BANKS-1:0]            bank_open,
    input logic [NUM_BANKS-1:0][ROW_W-1:0] open_row
);

    AST_CLOSED_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open[bank_i]) |=> (viol_o && viol_code_o == 3'd1)); // R2

    AST_ACT_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd1 && bank_open[bank_i]) |=> (viol_code_o == 3'd3 && bank_open[$past(bank_i)])); // R4

    AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd4) |=> !bank_open[$past(bank_i)]); // R7

    AST_CODE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_o == (viol_code_o != 3'd0) && viol_code_o <= 3'd5); // R8

    AST_QUIET_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == 3'd0 || cmd_i > 3'd4) |=> (!viol_o && $stable(bank_open))); // R9

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_row
        AST_ROW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(bank_open[b]) && bank_open[b]) |-> $stable(open_row[b])); // R4
    end

endmodule

bind sdram_cmd_checker sdram_cmd_rules_sva #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W)
) u_rules_sva (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .viol_o     (viol_o),
    .viol_code_o(viol_code_o),
    .bank_open  (bank_open),
    .open_row   (open_row)
);

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;

    localparam int CLK_PS = 7500;
    localparam int T_RCD  = (20000 + CLK_PS - 1) / CLK_PS;
    localparam int T_RC   = (65000 + CLK_PS - 1) / CLK_PS;
    localparam int T_RRD  = (15000 + CLK_PS - 1) / CLK_PS;
    localparam int SAT    = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  bank = 2'd0;
    logic [12:0] row = 13'd0;
    logic        viol;
    logic [2:0]  viol_code;

    int checks = 0;
    int failures = 0;
    int m_since [4];
    int m_any;
    bit m_open [4];
    int exp_prev;
    bit have_prev = 1'b0;
    string prev_tag;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sdram_cmd_checker i_sdram_cmd_checker (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .cmd_i      (cmd),
        .bank_i     (bank),
        .row_i      (row),
        .viol_o     (viol),
        .viol_code_o(viol_code)
    );

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) begin
            m_open[i]  = 1'b0;
            m_since[i] = SAT;
        end
        m_any = SAT;
    endfunction

    function automatic int model_apply(input int c, input int b);
        int code = 0;
        if (c == 2 || c == 3) begin
            if (!m_open[b])              code = 1;
            else if (m_since[b] < T_RCD) code = 2;
        end else if (c == 1) begin
            if (m_open[b])               code = 3;
            else if (m_since[b] < T_RC)  code = 4;
            else if (m_any < T_RRD)      code = 5;
        end
        for (int i = 0; i < 4; i++) if (m_since[i] < SAT) m_since[i]++;
        if (m_any < SAT) m_any++;
        if (c == 1 && code == 0) begin
            m_open[b]  = 1'b1;
            m_since[b] = 1;
            m_any      = 1;
        end
        if (c == 4) m_open[b] = 1'b0;
        return code;
    endfunction

    task automatic check_out(input int exp, input string tag);
        checks++;
        if (viol !== (exp != 0) || viol_code !== 3'(exp)) begin
            failures++;
            $display("FAIL %s: viol=%0b code=%0d expected viol=%0b code=%0d",
                     tag, viol, viol_code, (exp != 0), exp);
        end
    endtask

    task automatic step(input int c, input int b, input int r, input string tag);
        @(negedge clk);
        if (have_prev) check_out(exp_prev, prev_tag);
        cmd      = 3'(c);
        bank     = 2'(b);
        row      = 13'(r);
        exp_prev = model_apply(c, b);
        prev_tag = tag;
        have_prev = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        model_reset();
        repeat (3) @(negedge clk);
        check_out(0, "R10 reset outputs");
        rst_n = 1'b1;

        // reset state and activate-to-access window
        step(2, 0, 0, "R10 read after reset closed");
        step(1, 0, 5, "R10 first activate legal");
        step(2, 0, 0, "R3 read too early");
        step(0, 0, 0, "R9 nop");
        step(3, 0, 0, "R3 write at tRCD boundary");
        step(1, 0, 7, "R4 activate on open bank");
        step(2, 0, 0, "R4 bank still open");
        // cross-bank spacing
        step(1, 1, 9, "R6 other bank activate legal");
        step(1, 2, 3, "R6 activate inside tRRD");
        step(1, 2, 3, "R6 activate at tRRD boundary");
        step(5, 3, 0, "R9 unused command 5");
        step(7, 1, 0, "R9 unused command 7");
        // precharge on idle bank
        step(4, 3, 0, "R7 precharge idle bank");
        step(2, 3, 0, "R7 idle bank still closed");
        step(4, 1, 0, "R7 precharge open bank");
        step(3, 1, 0, "R7 write after close");
        // same-bank spacing and rejected activates
        repeat (3) step(0, 0, 0, "R9 nop gap");
        step(1, 3, 11, "R5 open bank 3");
        step(4, 3, 0, "R5 close bank 3");
        step(1, 3, 12, "R5 reopen inside tRC");
        step(2, 3, 0, "R11 rejected activate left bank closed");
        repeat (4) step(0, 0, 0, "R9 nop gap");
        step(1, 3, 12, "R1 activate one cycle before tRC");
        step(1, 3, 12, "R1 activate at tRC boundary");
        step(2, 3, 0, "R11 access inside tRCD after reopen");

        // weighted random traffic
        for (int n = 0; n < 3000; n++) begin
            int sel = $urandom_range(0, 9);
            int c;
            if (sel < 2)       c = 0;
            else if (sel < 5)  c = 1;
            else if (sel < 7)  c = 2;
            else if (sel == 7) c = 3;
            else if (sel == 8) c = 4;
            else               c = 5 + $urandom_range(0, 2);
            step(c, $urandom_range(0, 3), $urandom_range(0, 8191), "R8 random traffic");
        end

        @(negedge clk);
        check_out(exp_prev, prev_tag);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule